// File: doc/BRIEF.md
# Multi-Source Edge Interrupt Controller

This block collects sixteen interrupt sources (two encoder count-event pulses and fourteen external pins) and four parallel-port bits. It turns them into two sticky host interrupt lines, A and B. Each external pin passes through a synchroniser and an edge detector. A per-pin enable and a per-pin polarity decide whether a rising edge or a falling edge raises an event. The two encoder events are synchronous pulses, and each has its own enable. The OR of all enabled events forms the group source.

Each host line has a 4-bit source selector, an enable flag and a sticky latch. A selector of 0 picks the group. Selectors 12 to 15 pick one of the four parallel-port bits, and these bits fire on rising edges. Every other selector value picks nothing. The host drives each line with command bits that enable, disable or clear it. A status register records which group sources caused the line A event, and a line A clear also clears it. The host reaches all of this through a byte-wide, 4-bit-addressed register port. A single write to that port performs the same initialisation as the hardware reset.

Top module: `irq_edge_ctrl`

## Requirements
- R1: External pin k (k = 1..14) raises an event only when its enable bit is 1. With polarity 1 it fires on a low-to-high change, and with polarity 0 on a high-to-low change. The opposite edge does nothing. Pins 1 and 2 are configured at offset 5: pin 1 enable in bit 3 and polarity in bit 2, pin 2 enable in bit 1 and polarity in bit 0. Pins 3-6, 7-10 and 11-14 are configured at offsets 6, 7 and 8, with the first pin of each group in bits 7 (enable) and 6 (polarity), the next pin in bits 5 and 4, then bits 3 and 2, then bits 1 and 0.
- R2: Encoder events count only when enabled. The encoder 1 enable is bit 7 of offset 5 and the encoder 2 enable is bit 6; both are 0 after reset.
- R3: Status is read at offset 5 and offset 6. Offset 5 holds, from bit 7 downwards, encoder 1, encoder 2 and pins 1..6. Offset 6 holds pins 7..14, with pin 7 in bit 7. A status bit sets when its source takes part in a line A event while line A is enabled and selects the group. When several sources fire in one cycle, all their bits set together. Status holds until a line A clear or a reset.
- R4: The selector register is at offset 12 (0xC). Line B uses bits 7:4 and line A uses bits 3:0. Value 0 selects the group. Values 12, 13, 14 and 15 select parallel-port bits 0, 1, 2 and 3. Values 1 to 11 select no source.
- R5: After reset, both lines are low, the status bits are 0 and the selector register reads 0xC0 (line A 0, line B 12).
- R6: The command register is at offset 13 (0xD). Bits 2, 1 and 0 enable, disable and clear line A. Bits 6, 5 and 4 enable, disable and clear line B. Writing enable and disable together leaves the line disabled.
- R7: A line's latch sets when its selected source fires while the line is enabled. The latch then stays high until a clear command, even if the line is later disabled. A disabled line never sets.
- R8: Reading offset 13 returns the line B latch in bit 1 and the line A latch in bit 0. All other bits read 0.
- R9: Writing 1 to bit 0 of offset 15 (0xF) restores every reset value: the selectors, the lines, the status bits, the enables and the line enable flags.
- R10: An external pin change driven before clock edge k sets the line latch at edge k+2, and not earlier.
- R11: A parallel-port bit sets its line only on a rising edge; a falling edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| enc_evt_i | input | 2 | Encoder count-event pulses (bit 0 = encoder 1) |
| ext_pin_i | input | 14 | External interrupt pins (bit 0 = pin 1) |
| pp_bit_i | input | 4 | Parallel-port bits selectable by codes 12..15 |
| irq_a_o | output | 1 | Host interrupt line A |
| irq_b_o | output | 1 | Host interrupt line B |

## Verification
A register write takes effect at the clock edge that samples it. A write strobe held for one cycle is therefore visible at the next falling edge, and that is where the bench reads back. An encoder pulse is sampled at one edge and sets the line latch at that same edge. An external pin or a parallel-port bit sets the latch two edges after the edge that first samples it. The bench checks that the line is still low one falling edge before that and high at the following one. Level-sensitive results are read after four full cycles, which is longer than the synchroniser path.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
   localparam int unsigned BUS_AW = 4;
   localparam int unsigned BUS_DW = 8;

   typedef enum logic [BUS_AW-1:0] {
      OFF_CFG0 = 4'h5,
      OFF_CFG1 = 4'h6,
      OFF_CFG2 = 4'h7,
      OFF_CFG3 = 4'h8,
      OFF_SEL  = 4'hC,
      OFF_CMD  = 4'hD,
      OFF_INIT = 4'hF
   } reg_off_e;

   typedef struct packed {
      logic en;
      logic dis;
      logic clr;
   } line_cmd_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int unsigned WIDTH  = 14,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic [WIDTH-1:0] pin_i,
   input  logic [WIDTH-1:0] pol_i,
   output logic [WIDTH-1:0] ev_o
);
   localparam int unsigned CHAIN_W = STAGES * WIDTH;

   logic [CHAIN_W-1:0] chain_q;
   logic [WIDTH-1:0]   lvl;
   logic [WIDTH-1:0]   prev_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("irq_edge_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain_q <= '0;
         else if (init_i) chain_q <= '0;
         else             chain_q <= pin_i;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain_q <= '0;
         else if (init_i) chain_q <= '0;
         else             chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], pin_i};
      end
   end

   assign lvl = chain_q[CHAIN_W-1 -: WIDTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_q <= '0;
      else if (init_i) prev_q <= '0;
      else             prev_q <= lvl;
   end

   // an event is a change whose new level equals the requested polarity
   assign ev_o = (lvl ^ prev_q) & ~(lvl ^ pol_i);
endmodule

// File: rtl/irq_line.sv
module irq_line
   import irq_edge_pkg::*;
#(
   parameter int unsigned       SEL_W   = 4,
   parameter int unsigned       N_PP    = 4,
   parameter logic [SEL_W-1:0]  SEL_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             cmd_wr_i,
   input  line_cmd_t        cmd_i,
   input  logic             sel_wr_i,
   input  logic [SEL_W-1:0] sel_d_i,
   input  logic             group_fire_i,
   input  logic [N_PP-1:0]  pp_ev_i,
   output logic [SEL_W-1:0] sel_o,
   output logic             en_o,
   output logic             irq_o
);
   localparam int unsigned PP_BASE = (1 << SEL_W) - N_PP;

   logic [SEL_W-1:0] sel_q;
   logic             en_q;
   logic             line_q;
   logic             fire;

   if (N_PP >= (1 << SEL_W)) begin : g_bad_pp
      $error("irq_line: N_PP does not fit beside the group code");
   end

   always_comb begin
      fire = 1'b0;
      if (sel_q == '0) begin
         fire = group_fire_i;
      end else begin
         for (int p = 0; p < N_PP; p++) begin
            if (sel_q == SEL_W'(PP_BASE + p)) fire = pp_ev_i[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_q <= SEL_RST;
      else if (init_i)   sel_q <= SEL_RST;
      else if (sel_wr_i) sel_q <= sel_d_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (init_i) en_q <= 1'b0;
      else if (cmd_wr_i) begin
         if (cmd_i.dis)     en_q <= 1'b0;
         else if (cmd_i.en) en_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       line_q <= 1'b0;
      else if (init_i)                  line_q <= 1'b0;
      else if (cmd_wr_i && cmd_i.clr)   line_q <= 1'b0;
      else if (en_q && fire)            line_q <= 1'b1;
   end

   assign sel_o = sel_q;
   assign en_o  = en_q;
   assign irq_o = line_q;

   // R6
   dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && cmd_i.en && cmd_i.dis) |=> !en_o);

   // R6
   clr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && cmd_i.clr) |=> !irq_o);

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(cmd_wr_i && cmd_i.clr) && !init_i) |=> irq_o);

   // R7
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && !irq_o) |=> !irq_o);
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
   import irq_edge_pkg::*;
#(
   parameter int unsigned      N_ENC       = 2,
   parameter int unsigned      N_EXT       = 14,
   parameter int unsigned      N_PP        = 4,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      SEL_W       = 4,
   parameter logic [SEL_W-1:0] SEL_A_RST   = 4'd0,
   parameter logic [SEL_W-1:0] SEL_B_RST   = 4'd12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [3:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [N_ENC-1:0] enc_evt_i,
   input  logic [N_EXT-1:0] ext_pin_i,
   input  logic [N_PP-1:0]  pp_bit_i,
   output logic             irq_a_o,
   output logic             irq_b_o
);
   localparam int unsigned N_SRC   = N_ENC + N_EXT;
   localparam int unsigned N_LINES = 2;

   if (N_ENC != 2 || N_EXT < 1 || N_EXT > 14 || 2 * SEL_W != BUS_DW) begin : g_bad_cfg
      $error("irq_edge_ctrl: configuration does not fit the byte register map");
   end

   function automatic logic [3:0] cfg_off(input int i);
      return 4'((i < 2) ? 5 : 6 + (i - 2) / 4);
   endfunction

   function automatic logic [2:0] cfg_en_bit(input int i);
      return 3'((i < 2) ? 3 - 2 * i : 7 - 2 * ((i - 2) % 4));
   endfunction

   logic                 init;
   logic [N_ENC-1:0]     enc_en_q;
   logic [N_EXT-1:0]     ext_en_q;
   logic [N_EXT-1:0]     ext_pol_q;
   logic [N_EXT-1:0]     ext_edge;
   logic [N_PP-1:0]      pp_edge;
   logic [N_SRC-1:0]     src_ev;
   logic [N_SRC-1:0]     stat_q;
   logic [15:0]          stat_pad;
   logic                 group_fire;
   logic [SEL_W-1:0]     line_sel [N_LINES];
   logic [N_LINES-1:0]   line_en;
   logic [N_LINES-1:0]   line_irq;
   line_cmd_t            line_cmd [N_LINES];
   logic                 cmd_wr;
   logic                 sel_wr;

   assign init   = bus_wr && (bus_addr == OFF_INIT) && bus_wdata[0];
   assign cmd_wr = bus_wr && (bus_addr == OFF_CMD);
   assign sel_wr = bus_wr && (bus_addr == OFF_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || init) begin
         enc_en_q  <= '0;
         ext_en_q  <= '0;
         ext_pol_q <= '1;
      end else if (bus_wr) begin
         if (bus_addr == OFF_CFG0) begin
            for (int e = 0; e < N_ENC; e++) enc_en_q[e] <= bus_wdata[3'(7 - e)];
         end
         for (int i = 0; i < N_EXT; i++) begin
            if (bus_addr == cfg_off(i)) begin
               ext_en_q[i]  <= bus_wdata[cfg_en_bit(i)];
               ext_pol_q[i] <= bus_wdata[cfg_en_bit(i) - 3'd1];
            end
         end
      end
   end

   irq_edge_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES)) i_ext_sync (
      .clk(clk), .rst_n(rst_n), .init_i(init),
      .pin_i(ext_pin_i), .pol_i(ext_pol_q), .ev_o(ext_edge)
   );

   irq_edge_sync #(.WIDTH(N_PP), .STAGES(SYNC_STAGES)) i_pp_sync (
      .clk(clk), .rst_n(rst_n), .init_i(init),
      .pin_i(pp_bit_i), .pol_i({N_PP{1'b1}}), .ev_o(pp_edge)
   );

   assign src_ev     = {ext_edge & ext_en_q, enc_evt_i & enc_en_q};
   assign group_fire = |src_ev;

   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      localparam logic [SEL_W-1:0] RST_SEL = (l == 0) ? SEL_A_RST : SEL_B_RST;
      assign line_cmd[l] = line_cmd_t'(bus_wdata[l*4+2 -: 3]);
      irq_line #(.SEL_W(SEL_W), .N_PP(N_PP), .SEL_RST(RST_SEL)) i_line (
         .clk(clk), .rst_n(rst_n), .init_i(init),
         .cmd_wr_i(cmd_wr), .cmd_i(line_cmd[l]),
         .sel_wr_i(sel_wr), .sel_d_i(bus_wdata[l*SEL_W +: SEL_W]),
         .group_fire_i(group_fire), .pp_ev_i(pp_edge),
         .sel_o(line_sel[l]), .en_o(line_en[l]), .irq_o(line_irq[l])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || init)                     stat_q <= '0;
      else if (cmd_wr && line_cmd[0].clr)     stat_q <= '0;
      else if (line_en[0] && line_sel[0] == '0) stat_q <= stat_q | src_ev;
   end

   assign stat_pad = 16'(stat_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFF_CFG0: for (int k = 0; k < 8; k++) bus_rdata[3'(7 - k)] = stat_pad[4'(k)];
         OFF_CFG1: for (int k = 0; k < 8; k++) bus_rdata[3'(7 - k)] = stat_pad[4'(k + 8)];
         OFF_SEL:  bus_rdata = {line_sel[1], line_sel[0]};
         OFF_CMD:  bus_rdata[1:0] = line_irq;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_a_o = line_irq[0];
   assign irq_b_o = line_irq[1];

   // R3
   stat_implies_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|stat_q) |-> irq_a_o);

   // R9
   soft_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (line_sel[0] == SEL_A_RST && line_sel[1] == SEL_B_RST
                && !irq_a_o && !irq_b_o && line_en == '0));
endmodule

// File: tb/test_irq_edge_ctrl.sv
module test_irq_edge_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [1:0]  enc_evt = '0;
   logic [13:0] ext_pin = '0;
   logic [3:0]  pp_bit = '0;
   logic        irq_a, irq_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_edge_ctrl i_irq_edge_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_evt_i(enc_evt),
      .ext_pin_i(ext_pin), .pp_bit_i(pp_bit), .irq_a_o(irq_a), .irq_b_o(irq_b)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_enc(input logic [1:0] v);
      @(negedge clk); enc_evt = v;
      @(negedge clk); enc_evt = '0;
   endtask

   task automatic clear_cfg();
      for (int o = 5; o <= 8; o++) wr(4'(o), 8'h00);
   endtask

   function automatic int cfg_off(input int i);
      return (i < 2) ? 5 : 6 + (i - 2) / 4;
   endfunction

   function automatic int cfg_en(input int i);
      return (i < 2) ? 3 - 2 * i : 7 - 2 * ((i - 2) % 4);
   endfunction

   initial begin : watchdog
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 reset state
      chk("R5 irq_a", {7'b0, irq_a}, 8'h00);
      chk("R5 irq_b", {7'b0, irq_b}, 8'h00);
      rd(4'hC, d); chk("R5 selectors", d, 8'hC0);
      rd(4'h5, d); chk("R5 status lo", d, 8'h00);
      rd(4'h6, d); chk("R5 status hi", d, 8'h00);
      rd(4'hD, d); chk("R8 line readback", d, 8'h00);

      // R1 R3 R10 R8: every pin, both polarities
      for (int i = 0; i < 14; i++) begin
         for (int p = 0; p < 2; p++) begin
            int idx;
            logic [7:0] e5, e6;
            idx = 2 + i;
            e5 = (idx < 8) ? 8'(1 << (7 - idx)) : 8'h00;
            e6 = (idx >= 8) ? 8'(1 << (15 - idx)) : 8'h00;
            clear_cfg();
            wr(4'hD, 8'h05);
            ext_pin[i] = p[0];
            settle();
            wr(4'(cfg_off(i)), 8'((1 << cfg_en(i)) | (p << (cfg_en(i) - 1))));
            ext_pin[i] = ~p[0];
            settle();
            chk($sformatf("R1 pin%0d pol%0d wrong edge", i + 1, p), {7'b0, irq_a}, 8'h00);
            ext_pin[i] = p[0];
            @(negedge clk);
            @(negedge clk);
            chk($sformatf("R10 pin%0d early", i + 1), {7'b0, irq_a}, 8'h00);
            @(negedge clk);
            chk($sformatf("R10 pin%0d due", i + 1), {7'b0, irq_a}, 8'h01);
            rd(4'h5, d); chk($sformatf("R3 pin%0d status lo", i + 1), d, e5);
            rd(4'h6, d); chk($sformatf("R3 pin%0d status hi", i + 1), d, e6);
            rd(4'hD, d); chk("R8 line A readback", d, 8'h01);
            wr(4'hD, 8'h01);
            chk("R6 clear A", {7'b0, irq_a}, 8'h00);
            rd(4'h5, d); chk("R3 clear lo", d, 8'h00);
            rd(4'h6, d); chk("R3 clear hi", d, 8'h00);
            ext_pin[i] = 1'b0;
            settle();
         end
      end

      // R2 encoder enables
      clear_cfg();
      wr(4'hD, 8'h05);
      pulse_enc(2'b01);
      chk("R2 enc1 disabled", {7'b0, irq_a}, 8'h00);
      wr(4'h5, 8'h80);
      pulse_enc(2'b01);
      chk("R2 enc1 fires", {7'b0, irq_a}, 8'h01);
      rd(4'h5, d); chk("R2 enc1 status", d, 8'h80);
      wr(4'hD, 8'h01);
      pulse_enc(2'b10);
      chk("R2 enc2 disabled", {7'b0, irq_a}, 8'h00);
      wr(4'h5, 8'h40);
      pulse_enc(2'b10);
      rd(4'h5, d); chk("R2 enc2 status", d, 8'h40);
      wr(4'hD, 8'h01);

      // R3 simultaneous sources
      wr(4'h5, 8'h0C);
      wr(4'h8, 8'h03);
      ext_pin[0] = 1'b1; ext_pin[13] = 1'b1;
      settle();
      rd(4'h5, d); chk("R3 simultaneous lo", d, 8'h20);
      rd(4'h6, d); chk("R3 simultaneous hi", d, 8'h01);

      // R7 sticky through disable, then disabled line stays quiet
      wr(4'hD, 8'h02);
      chk("R7 sticky after disable", {7'b0, irq_a}, 8'h01);
      wr(4'hD, 8'h01);
      chk("R7 cleared", {7'b0, irq_a}, 8'h00);
      ext_pin[0] = 1'b0; settle();
      ext_pin[0] = 1'b1; settle();
      chk("R7 disabled line", {7'b0, irq_a}, 8'h00);

      // R6 enable and disable together
      wr(4'hD, 8'h04);
      wr(4'hD, 8'h06);
      ext_pin[0] = 1'b0; settle();
      ext_pin[0] = 1'b1; settle();
      chk("R6 disable wins", {7'b0, irq_a}, 8'h00);
      wr(4'hD, 8'h04);
      ext_pin[0] = 1'b0; settle();
      ext_pin[0] = 1'b1; settle();
      chk("R6 enable works", {7'b0, irq_a}, 8'h01);
      wr(4'hD, 8'h01);
      ext_pin[0] = 1'b0; ext_pin[13] = 1'b0;
      clear_cfg();
      settle();

      // R4 selector sweep on line B over parallel-port bits
      for (int s = 12; s < 16; s++) begin
         wr(4'hC, 8'(s << 4));
         for (int b = 0; b < 4; b++) begin
            wr(4'hD, 8'h50);
            pp_bit[b] = 1'b1; settle();
            chk($sformatf("R4 selB=%0d bit%0d", s, b), {7'b0, irq_b}, {7'b0, (b == s - 12)});
            chk("R4 line A untouched", {7'b0, irq_a}, 8'h00);
            pp_bit[b] = 1'b0; settle();
            wr(4'hD, 8'h10);
         end
      end

      // R4 unused codes select nothing
      for (int s = 1; s < 12; s += 5) begin
         wr(4'hC, 8'(s << 4));
         wr(4'hD, 8'h50);
         pp_bit = 4'hF; settle();
         chk($sformatf("R4 selB=%0d none", s), {7'b0, irq_b}, 8'h00);
         pp_bit = 4'h0; settle();
      end

      // R11 falling parallel-port edge ignored
      wr(4'hC, 8'hC0);
      wr(4'hD, 8'h20);
      pp_bit[0] = 1'b1; settle();
      wr(4'hD, 8'h50);
      pp_bit[0] = 1'b0; settle();
      chk("R11 falling ignored", {7'b0, irq_b}, 8'h00);
      pp_bit[0] = 1'b1; settle();
      chk("R11 rising fires", {7'b0, irq_b}, 8'h01);
      pp_bit[0] = 1'b0; settle();

      // R4 line A: unused code then port bit code
      wr(4'hC, 8'hC5);
      wr(4'h5, 8'h80);
      wr(4'hD, 8'h05);
      pulse_enc(2'b01);
      chk("R4 selA=5 none", {7'b0, irq_a}, 8'h00);
      wr(4'hC, 8'hCD);
      pp_bit[1] = 1'b1; settle();
      chk("R4 selA=13 port bit1", {7'b0, irq_a}, 8'h01);
      pp_bit[1] = 1'b0;

      // R9 soft reset
      wr(4'hF, 8'h01);
      chk("R9 irq_a", {7'b0, irq_a}, 8'h00);
      chk("R9 irq_b", {7'b0, irq_b}, 8'h00);
      rd(4'hC, d); chk("R9 selectors", d, 8'hC0);
      rd(4'hD, d); chk("R9 lines", d, 8'h00);
      wr(4'hD, 8'h04);
      pulse_enc(2'b01);
      chk("R9 encoder enable cleared", {7'b0, irq_a}, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule